// File: doc/BRIEF.md
# Multiplexed Pixel Port Serializer

This block sits between a set of parallel frame-buffer banks and a pixel-rate datapath. Up to four banks each present one 24-bit color word plus a two-bit palette-select field. The whole set is latched on the rising edge of a slow load strobe, and the block then emits one pixel per pixel-clock cycle. Three multiplex ratios are supported. In 4:1 mode each load supplies four pixels, in 2:1 mode two, and in 1:1 mode one.

The load strobe runs at the pixel clock divided by the multiplex ratio. Its phase relative to the pixel clock is arbitrary. The block captures the banks in the strobe's own domain into one of two alternating slots. A toggle flag tells the pixel-clock domain which slot was filled last. After the toggle has been synchronized, the slot is copied into a holding register, and a bank counter walks through it. Sync and blank are sampled once per load and stay with every pixel of that load. In 1:1 mode the strobe path is bypassed and bank A is sampled on every pixel clock.

The output is a stream with a valid flag and no ready. There is no back-pressure: once valid rises, the consumer must take one pixel on every pixel-clock cycle for as long as valid stays high. Valid drops only when the mode register is written.

Top module: `pixmux_serializer`

## Requirements
- R1: The mode register resets to 4:1 and is written from `cfg_mode_i` when `cfg_we_i` is high at a pixel-clock edge. The encodings are 2'b00 for 1:1, 2'b01 for 2:1 and 2'b10 for 4:1, and the code 2'b11 behaves as 4:1.
- R2: On each rising edge of `load_i`, all four bank color words, all four palette-select fields, `sync_i` and `blank_i` are captured together. The output reproduces them bit for bit.
- R3: In 4:1 mode, each load produces four consecutive output pixels, in the order bank A, B, C, D. Bank A is bits [23:0] of `bank_color_i`, B is [47:24], C is [71:48] and D is [95:72].
- R4: In 2:1 mode, each load produces two consecutive output pixels, bank A then bank B. Banks C and D are not output.
- R5: In 1:1 mode, bank A, its palette-select bits, sync and blank are sampled on every pixel-clock edge and appear at the outputs two edges later. `load_i` and banks B to D have no effect on the outputs.
- R6: Each output pixel carries the palette-select field of the same bank as its color. Bank A's field is bits [1:0] of `bank_psel_i`, B's is [3:2], C's is [5:4] and D's is [7:6].
- R7: `pix_sync_o` and `pix_blank_o` keep the values captured with a load for every pixel produced from that load.
- R8: When `SYNC_STAGES` is 2, the first valid pixel after a load appears on the fourth pixel-clock rising edge after the `load_i` rise, and it is bank A.
- R9: The latency of R8 holds for any phase of `load_i` within a pixel-clock period.
- R10: Writing the mode register drops `pix_valid_o` at that same edge. Valid stays low until the next load is transferred, or in 1:1 mode until the bypass path refills.
- R11: After reset, `pix_valid_o` is low and every output data bit is zero.
- R12: While the strobe keeps running at the ratio set by the mode register, `pix_valid_o` stays high on every cycle with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| load_i | input | 1 | Load strobe; banks are captured on its rising edge |
| cfg_we_i | input | 1 | Mode register write enable, sampled on `clk_pix` |
| cfg_mode_i | input | 2 | Mode code written on `cfg_we_i` |
| bank_color_i | input | 96 | Four 24-bit bank color words, bank A lowest |
| bank_psel_i | input | 8 | Four 2-bit palette-select fields, bank A lowest |
| sync_i | input | 1 | Sync flag captured per load |
| blank_i | input | 1 | Blank flag captured per load |
| pix_valid_o | output | 1 | Output pixel is valid; no ready exists |
| pix_color_o | output | 24 | Serialized color word |
| pix_psel_o | output | 2 | Palette-select bits of the current pixel |
| pix_sync_o | output | 1 | Sync flag of the current pixel's load |
| pix_blank_o | output | 1 | Blank flag of the current pixel's load |

## Verification
The bench builds the block with its defaults: 24-bit color, two palette-select bits and a two-stage synchronizer. These fix the load-to-pixel latency at four pixel-clock edges, so the bench can check that latency exactly. It also varies the strobe phase across the pixel period (2, 3 and 6 ns after a pixel-clock edge), which exercises the phase tolerance of the slot hand-off. With four banks present, every ordering can be checked: the full 4:1 walk, the 2:1 walk, the 1:1 bypass, and the reserved mode code.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  localparam int unsigned NUM_BANKS  = 4;
  localparam int unsigned BANK_IDX_W = $clog2(NUM_BANKS);

  typedef enum logic [1:0] {
    MUX_1TO1 = 2'b00,
    MUX_2TO1 = 2'b01,
    MUX_4TO1 = 2'b10,
    MUX_RSVD = 2'b11
  } mux_mode_e;

  // Index of the final bank walked per load for a given ratio.
  function automatic logic [BANK_IDX_W-1:0] last_bank(input mux_mode_e m);
    case (m)
      MUX_1TO1: last_bank = '0;
      MUX_2TO1: last_bank = BANK_IDX_W'(1);
      default:  last_bank = BANK_IDX_W'(NUM_BANKS - 1);
    endcase
  endfunction

endpackage

// File: rtl/pxs_capture.sv
// Load-strobe domain: alternating capture slots plus a toggle flag.
module pxs_capture #(
  parameter int unsigned COLOR_W = 24,
  parameter int unsigned PSEL_W  = 2,
  parameter int unsigned NBANK   = 4
) (
  input  logic                                load_i,
  input  logic                                rst_n,
  input  logic [NBANK*COLOR_W-1:0]            bank_color_i,
  input  logic [NBANK*PSEL_W-1:0]             bank_psel_i,
  input  logic                                sync_i,
  input  logic                                blank_i,
  output logic                                wsel_o,
  output logic [1:0][NBANK*COLOR_W-1:0]       slot_color_o,
  output logic [1:0][NBANK*PSEL_W-1:0]        slot_psel_o,
  output logic [1:0]                          slot_sync_o,
  output logic [1:0]                          slot_blank_o
);

  always_ff @(posedge load_i or negedge rst_n) begin
    if (!rst_n) wsel_o <= 1'b0;
    else        wsel_o <= ~wsel_o;
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [NBANK*COLOR_W-1:0] col_q;
    logic [NBANK*PSEL_W-1:0]  psel_q;
    logic                     sync_q;
    logic                     blank_q;

    always_ff @(posedge load_i or negedge rst_n) begin
      if (!rst_n) begin
        col_q   <= '0;
        psel_q  <= '0;
        sync_q  <= 1'b0;
        blank_q <= 1'b0;
      end else if (wsel_o == 1'(s)) begin
        col_q   <= bank_color_i;
        psel_q  <= bank_psel_i;
        sync_q  <= sync_i;
        blank_q <= blank_i;
      end
    end

    assign slot_color_o[s] = col_q;
    assign slot_psel_o[s]  = psel_q;
    assign slot_sync_o[s]  = sync_q;
    assign slot_blank_o[s] = blank_q;
  end

endmodule

// File: rtl/pxs_toggle_sync.sv
// Brings the slot toggle into the pixel domain and flags each change.
module pxs_toggle_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_i,
  output logic chg_o,
  output logic sel_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], tog_i};
  end

  // A change means a new slot is stable; the slot just filled is the old toggle value.
  assign chg_o = sh_q[STAGES] ^ sh_q[STAGES-1];
  assign sel_o = sh_q[STAGES];

endmodule

// File: rtl/pxs_serial.sv
// Pixel domain: mode register, holding register, bank walk and output stage.
module pxs_serial
  import pxs_pkg::*;
#(
  parameter int unsigned COLOR_W = 24,
  parameter int unsigned PSEL_W  = 2,
  parameter int unsigned NBANK   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we_i,
  input  logic [1:0]                    cfg_mode_i,
  input  logic                          xfer_i,
  input  logic                          sel_i,
  input  logic [1:0][NBANK*COLOR_W-1:0] slot_color_i,
  input  logic [1:0][NBANK*PSEL_W-1:0]  slot_psel_i,
  input  logic [1:0]                    slot_sync_i,
  input  logic [1:0]                    slot_blank_i,
  input  logic [COLOR_W-1:0]            dir_color_i,
  input  logic [PSEL_W-1:0]             dir_psel_i,
  input  logic                          dir_sync_i,
  input  logic                          dir_blank_i,
  output logic                          pix_valid_o,
  output logic [COLOR_W-1:0]            pix_color_o,
  output logic [PSEL_W-1:0]             pix_psel_o,
  output logic                          pix_sync_o,
  output logic                          pix_blank_o
);

  localparam int unsigned IW = BANK_IDX_W;

  mux_mode_e                        mode_q;
  logic                             is_one;
  logic [IW-1:0]                    last_idx;
  logic [NBANK-1:0][COLOR_W-1:0]    hold_color;
  logic [NBANK-1:0][PSEL_W-1:0]     hold_psel;
  logic                             hold_sync;
  logic                             hold_blank;
  logic                             primed;
  logic [IW-1:0]                    cnt;
  logic [IW-1:0]                    pos_q;

  assign is_one   = (mode_q == MUX_1TO1);
  assign last_idx = last_bank(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MUX_4TO1;
      hold_color <= '0;
      hold_psel  <= '0;
      hold_sync  <= 1'b0;
      hold_blank <= 1'b0;
      primed     <= 1'b0;
      cnt        <= '0;
    end else if (cfg_we_i) begin
      mode_q <= mux_mode_e'(cfg_mode_i);
      primed <= 1'b0;
      cnt    <= '0;
    end else if (is_one) begin
      hold_color[0] <= dir_color_i;
      hold_psel[0]  <= dir_psel_i;
      hold_sync     <= dir_sync_i;
      hold_blank    <= dir_blank_i;
      primed        <= 1'b1;
      cnt           <= '0;
    end else if (xfer_i) begin
      hold_color <= slot_color_i[sel_i];
      hold_psel  <= slot_psel_i[sel_i];
      hold_sync  <= slot_sync_i[sel_i];
      hold_blank <= slot_blank_i[sel_i];
      primed     <= 1'b1;
      cnt        <= '0;
    end else if (cnt == last_idx) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid_o <= 1'b0;
      pix_color_o <= '0;
      pix_psel_o  <= '0;
      pix_sync_o  <= 1'b0;
      pix_blank_o <= 1'b0;
      pos_q       <= '0;
    end else begin
      pix_valid_o <= primed && !cfg_we_i;
      pix_color_o <= hold_color[cnt];
      pix_psel_o  <= hold_psel[cnt];
      pix_sync_o  <= hold_sync;
      pix_blank_o <= hold_blank;
      pos_q       <= cnt;
    end
  end

  // R10: a mode write removes valid at the next output
  a_r10_cfg_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> !pix_valid_o);

  // R3: the bank walk never passes the last bank of the active ratio
  a_r3_walk_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx);

  // R7: sync and blank hold across the later pixels of one load
  a_r7_side_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid_o && $past(pix_valid_o) && pos_q != '0) |->
      ($stable(pix_sync_o) && $stable(pix_blank_o)));

  // R8: the stream always starts on bank A
  a_r8_first_is_bank_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid_o) |-> pos_q == '0);

  // R5: in the bypass path the output is bank A from two edges back
  a_r5_bypass_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (is_one && $past(is_one) && pix_valid_o && $past(pix_valid_o)) |->
      pix_color_o == $past(dir_color_i, 2));

  // R12: with a locked strobe, transfers are never back to back outside 1:1
  a_r12_xfer_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_one && xfer_i) |=> !xfer_i);

endmodule

// File: rtl/pixmux_serializer.sv
module pixmux_serializer #(
  parameter int unsigned COLOR_W     = 24,
  parameter int unsigned PSEL_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                     clk_pix,
  input  logic                                     rst_n,
  input  logic                                     load_i,
  input  logic                                     cfg_we_i,
  input  logic [1:0]                               cfg_mode_i,
  input  logic [pxs_pkg::NUM_BANKS*COLOR_W-1:0]    bank_color_i,
  input  logic [pxs_pkg::NUM_BANKS*PSEL_W-1:0]     bank_psel_i,
  input  logic                                     sync_i,
  input  logic                                     blank_i,
  output logic                                     pix_valid_o,
  output logic [COLOR_W-1:0]                       pix_color_o,
  output logic [PSEL_W-1:0]                        pix_psel_o,
  output logic                                     pix_sync_o,
  output logic                                     pix_blank_o
);

  localparam int unsigned NBANK = pxs_pkg::NUM_BANKS;

  logic                          wsel;
  logic [1:0][NBANK*COLOR_W-1:0] slot_color;
  logic [1:0][NBANK*PSEL_W-1:0]  slot_psel;
  logic [1:0]                    slot_sync;
  logic [1:0]                    slot_blank;
  logic                          xfer;
  logic                          sel;

  pxs_capture #(.COLOR_W(COLOR_W), .PSEL_W(PSEL_W), .NBANK(NBANK)) u_cap (
    .load_i       (load_i),
    .rst_n        (rst_n),
    .bank_color_i (bank_color_i),
    .bank_psel_i  (bank_psel_i),
    .sync_i       (sync_i),
    .blank_i      (blank_i),
    .wsel_o       (wsel),
    .slot_color_o (slot_color),
    .slot_psel_o  (slot_psel),
    .slot_sync_o  (slot_sync),
    .slot_blank_o (slot_blank)
  );

  pxs_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_pix),
    .rst_n (rst_n),
    .tog_i (wsel),
    .chg_o (xfer),
    .sel_o (sel)
  );

  pxs_serial #(.COLOR_W(COLOR_W), .PSEL_W(PSEL_W), .NBANK(NBANK)) u_ser (
    .clk          (clk_pix),
    .rst_n        (rst_n),
    .cfg_we_i     (cfg_we_i),
    .cfg_mode_i   (cfg_mode_i),
    .xfer_i       (xfer),
    .sel_i        (sel),
    .slot_color_i (slot_color),
    .slot_psel_i  (slot_psel),
    .slot_sync_i  (slot_sync),
    .slot_blank_i (slot_blank),
    .dir_color_i  (bank_color_i[COLOR_W-1:0]),
    .dir_psel_i   (bank_psel_i[PSEL_W-1:0]),
    .dir_sync_i   (sync_i),
    .dir_blank_i  (blank_i),
    .pix_valid_o  (pix_valid_o),
    .pix_color_o  (pix_color_o),
    .pix_psel_o   (pix_psel_o),
    .pix_sync_o   (pix_sync_o),
    .pix_blank_o  (pix_blank_o)
  );

endmodule

// File: tb/tb_pixmux_serializer.sv
module tb_pixmux_serializer;

  logic        clk_pix = 1'b0;
  logic        rst_n;
  logic        load_i;
  logic        cfg_we_i;
  logic [1:0]  cfg_mode_i;
  logic [95:0] bank_color_i;
  logic [7:0]  bank_psel_i;
  logic        sync_i;
  logic        blank_i;
  logic        pix_valid_o;
  logic [23:0] pix_color_o;
  logic [1:0]  pix_psel_o;
  logic        pix_sync_o;
  logic        pix_blank_o;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic        mon_en = 1'b0;
  int          cap_n = 0;
  logic [23:0] cap_color [64];
  logic [1:0]  cap_psel  [64];
  logic        cap_sync  [64];
  logic        cap_blank [64];
  int          cap_cyc   [64];
  int          ref_cyc;

  pixmux_serializer dut (
    .clk_pix(clk_pix), .rst_n(rst_n), .load_i(load_i),
    .cfg_we_i(cfg_we_i), .cfg_mode_i(cfg_mode_i),
    .bank_color_i(bank_color_i), .bank_psel_i(bank_psel_i),
    .sync_i(sync_i), .blank_i(blank_i),
    .pix_valid_o(pix_valid_o), .pix_color_o(pix_color_o),
    .pix_psel_o(pix_psel_o), .pix_sync_o(pix_sync_o), .pix_blank_o(pix_blank_o)
  );

  always #4ns clk_pix = ~clk_pix;
  always @(posedge clk_pix) cyc <= cyc + 1;

  always @(negedge clk_pix) begin
    if (mon_en && pix_valid_o && cap_n < 64) begin
      cap_color[cap_n] = pix_color_o;
      cap_psel[cap_n]  = pix_psel_o;
      cap_sync[cap_n]  = pix_sync_o;
      cap_blank[cap_n] = pix_blank_o;
      cap_cyc[cap_n]   = cyc;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_color(input int g, input int b);
    logic [7:0] gg;
    gg = 8'(g);
    return {gg + 8'h10, 8'(b) + 8'hB0, gg ^ 8'h5A};
  endfunction

  function automatic logic [1:0] exp_psel(input int g, input int b);
    return 2'(g + b);
  endfunction

  task automatic drive_group(input int g);
    for (int b = 0; b < 4; b++) begin
      bank_color_i[b*24 +: 24] = exp_color(g, b);
      bank_psel_i[b*2 +: 2]    = exp_psel(g, b);
    end
    sync_i  = g[0];
    blank_i = g[1];
  endtask

  task automatic cfg_write(input logic [1:0] code);
    @(posedge clk_pix); #1ns;
    cfg_we_i = 1'b1; cfg_mode_i = code;
    @(posedge clk_pix); #1ns;
    cfg_we_i = 1'b0;
  endtask

  // Frequency-locked strobe: rises off ns after a pixel edge, period m clocks.
  task automatic run_groups(input int m, input int off, input int ng, input int base);
    @(posedge clk_pix); #1ns;
    ref_cyc = cyc;
    for (int g = 0; g < ng; g++) begin
      drive_group(base + g);
      #((off - 1) * 1ns) load_i = 1'b1;
      #((m * 4) * 1ns) load_i = 1'b0;
      #((m * 4 - off + 1) * 1ns);
    end
  endtask

  task automatic t_reset();
    chk(pix_valid_o == 1'b0, "R11", "valid after reset", pix_valid_o, 0);
    chk(pix_color_o == 24'h0 && pix_psel_o == 2'b0 && !pix_sync_o && !pix_blank_o,
        "R11", "data after reset", pix_color_o, 0);
  endtask

  task automatic t_mux(input bit do_cfg, input logic [1:0] code, input int m,
                       input int off, input int ng, input int base);
    string rq;
    rq = (m == 2) ? "R4" : "R3";
    if (do_cfg) cfg_write(code);
    repeat (3) @(posedge clk_pix);
    cap_n = 0;
    mon_en = 1'b1;
    run_groups(m, off, ng, base);
    repeat (8) @(posedge clk_pix);
    mon_en = 1'b0;
    chk(cap_n >= ng * m, "R12", "pixel count", cap_n, ng * m);
    if (cap_n > 0) begin
      chk(cap_cyc[0] - ref_cyc == 4, (off == 3) ? "R8" : "R9", "first pixel latency",
          cap_cyc[0] - ref_cyc, 4);
      if (code == 2'b11)
        chk(cap_color[0] == exp_color(base, 0), "R1", "reserved code as 4:1",
            cap_color[0], exp_color(base, 0));
    end
    for (int i = 0; i < ng * m && i < cap_n; i++) begin
      int g = base + i / m;
      int b = i % m;
      if (b == 0)
        chk(cap_color[i] == exp_color(g, 0), "R2", "captured bank A", cap_color[i], exp_color(g, 0));
      chk(cap_color[i] == exp_color(g, b), rq, "bank order color", cap_color[i], exp_color(g, b));
      chk(cap_psel[i] == exp_psel(g, b), "R6", "palette select", cap_psel[i], exp_psel(g, b));
      chk(cap_sync[i] == g[0] && cap_blank[i] == g[1], "R7", "sync/blank per load",
          {cap_sync[i], cap_blank[i]}, {g[0], g[1]});
      chk(cap_cyc[i] == cap_cyc[0] + i, "R12", "no gap", cap_cyc[i], cap_cyc[0] + i);
    end
    if (code == 2'b11 && cap_n >= 4)
      chk(cap_color[3] == exp_color(base, 3), "R1", "reserved code walks to bank D",
          cap_color[3], exp_color(base, 3));
  endtask

  task automatic t_cfg_drop();
    #3ns;
    chk(pix_valid_o == 1'b1, "R12", "valid before mode write", pix_valid_o, 1);
    cfg_write(2'b10);
    #3ns;
    chk(pix_valid_o == 1'b0, "R10", "valid after mode write", pix_valid_o, 0);
    repeat (10) @(posedge clk_pix);
    #4ns;
    chk(pix_valid_o == 1'b0, "R10", "no restart without load", pix_valid_o, 0);
  endtask

  task automatic t_one_to_one();
    logic [23:0] d [32];
    logic [1:0]  p [32];
    logic        s [32];
    logic        k [32];
    cfg_write(2'b00);
    repeat (3) @(posedge clk_pix);
    for (int i = 0; i < 24; i++) begin
      @(posedge clk_pix); #1ns;
      d[i] = 24'(i * 32'h010203 + 32'h00A0B0);
      p[i] = 2'(i) ^ 2'b01;
      s[i] = i[0];
      k[i] = i[2];
      bank_color_i = {~d[i], d[i] ^ 24'hFFF000, 24'(i * 7), d[i]};
      bank_psel_i  = {2'(i + 1), 2'(i + 2), ~p[i], p[i]};
      sync_i  = s[i];
      blank_i = k[i];
      if (i % 3 == 0) load_i = ~load_i;
      #3ns;
      if (i >= 2) begin
        chk(pix_valid_o == 1'b1, "R5", "valid in 1:1", pix_valid_o, 1);
        chk(pix_color_o == d[i-2], "R5", "bank A color", pix_color_o, d[i-2]);
        chk(pix_psel_o == p[i-2] && pix_sync_o == s[i-2] && pix_blank_o == k[i-2],
            "R5", "bank A sideband", {pix_psel_o, pix_sync_o, pix_blank_o},
            {p[i-2], s[i-2], k[i-2]});
      end
    end
    @(posedge clk_pix); #1ns;
    load_i = 1'b0;
    repeat (6) @(posedge clk_pix);
  endtask

  initial begin
    #(200000 * 8ns);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    load_i = 1'b0;
    cfg_we_i = 1'b0;
    cfg_mode_i = 2'b00;
    bank_color_i = '0;
    bank_psel_i = '0;
    sync_i = 1'b0;
    blank_i = 1'b0;
    repeat (3) @(posedge clk_pix);
    #1ns rst_n = 1'b1;
    #3ns;
    t_reset();
    t_mux(1'b0, 2'b10, 4, 3, 5, 0);   // reset default ratio, R1
    t_cfg_drop();
    t_mux(1'b1, 2'b01, 2, 6, 6, 20);
    t_mux(1'b1, 2'b10, 4, 6, 4, 40);
    t_one_to_one();
    t_mux(1'b1, 2'b11, 4, 2, 3, 60);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule